// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block drives the active-low reset line of a host processor and two control lines toward a serial slave interface. Three conditions pull the reset low. The first is a digital supply-low flag from an external comparator. The second is the start-up hold that follows once the supply is good again. The third is a watchdog that times out when the serial bus shows no start or stop condition for too long.

While the supply is low, the block tells the serial slave to drop any transaction it is running and to refuse new commands. A nonvolatile write that is already busy is never cut short. The command block stays raised after the reset releases, for as long as that write still reports busy. For the whole of any reset period, bus activity has no effect on the watchdog. The start-up hold, the watchdog timeout and the watchdog pulse width are parameters counted in clock cycles.

Top module: `supervisor_wdt`

## Requirements
- R1: `lowVolt` passes through a two-flop synchronizer. If `lowVolt` goes high before clock edge k, `hostRstN` is still high after edge k+1 and is low after edge k+2. It stays low for as long as `lowVolt` stays high.
- R2: `commAbort` is high exactly while the block is in low-voltage reset. This includes the period that follows `porN` going low. `cmdBlock` is high throughout that same period.
- R3: If `nvBusy` is high while low-voltage reset is active, `cmdBlock` stays high after `hostRstN` releases. It falls after the first clock edge that samples `nvBusy` low. The release time of `hostRstN` does not depend on `nvBusy`.
- R4: Suppose the synchronized supply-low flag clears, either after `porN` or after a low-voltage episode, and `lowVolt` went low before edge k. Then `hostRstN` stays low through edge k+1+PWRUP_CYCLES and goes high after edge k+2+PWRUP_CYCLES.
- R5: A kick is a high level on `startDet` or `stopDet` at a clock edge. If the last kick is sampled at edge k and no further kick follows, `hostRstN` is high after edge k+WDT_CYCLES-1 and low after edge k+WDT_CYCLES. Kicks spaced WDT_CYCLES cycles apart or closer never cause a reset.
- R6: A watchdog reset pulse holds `hostRstN` low for exactly PULSE_CYCLES cycles. During the pulse `cmdBlock` is high and `commAbort` is low.
- R7: Kicks that arrive during any reset period are ignored. They neither lengthen nor shorten a watchdog pulse.
- R8: When a watchdog pulse ends at edge r, a fresh timeout starts. With no kicks, the next pulse begins after edge r+WDT_CYCLES.
- R9: A supply-low flag that arrives during a watchdog pulse takes over. The block enters low-voltage reset: `commAbort` rises and `hostRstN` stays low past the end of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Asynchronous power-on clear, active low |
| lowVolt | input | 1 | Supply-below-threshold flag from the comparator, asynchronous |
| startDet | input | 1 | Start condition seen on the serial bus |
| stopDet | input | 1 | Stop condition seen on the serial bus |
| nvBusy | input | 1 | A nonvolatile write is in progress |
| hostRstN | output | 1 | Reset to the host, active low |
| commAbort | output | 1 | Abort the current serial transaction |
| cmdBlock | output | 1 | Refuse new serial commands |

## Verification
The state register and a single shared counter decide every output. A counter that starts from the wrong value therefore moves the rising or falling edge of `hostRstN` by whole cycles, and that shift is visible on the first pulse or release that follows. A wrong state decode shows at once as an inconsistent set of outputs. Examples are `commAbort` rising during a watchdog pulse, or `cmdBlock` falling while the host is still held in reset. A sticky write-drain flag that is set or cleared at the wrong time shows within one edge of `nvBusy` changing.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [1:0] {
    ST_LV    = 2'd0,
    ST_PWRUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_WDRST = 2'd3
  } supState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } ctlStrobes_t;

endpackage

// File: rtl/sup_datapath.sv
module sup_datapath
  import sup_pkg::*;
#(
  parameter int PWRUP_CYCLES = 20,
  parameter int WDT_CYCLES   = 30,
  parameter int PULSE_CYCLES = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        lowVoltIn,
  input  ctlStrobes_t strobes,
  output logic        lvSync,
  output logic        atPwrup,
  output logic        atWdt,
  output logic        atPulse
);

  localparam int MAX_AB  = (PWRUP_CYCLES > WDT_CYCLES) ? PWRUP_CYCLES : WDT_CYCLES;
  localparam int CNT_MAX = (MAX_AB > PULSE_CYCLES) ? MAX_AB : PULSE_CYCLES;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0]          cnt;

  // Synchronizer chain; reset to "supply low" so start-up begins held.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) syncQ <= '1;
        else       syncQ <= lowVoltIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], lowVoltIn};
      end
    end
  endgenerate

  assign lvSync = syncQ[SYNC_STAGES-1];

  // One counter serves the start-up hold, the watchdog interval and the pulse.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                cnt <= '0;
    else if (strobes.cntClr)  cnt <= '0;
    else if (strobes.cntInc)  cnt <= cnt + 1'b1;
  end

  assign atPwrup = (cnt == CW'(PWRUP_CYCLES - 1));
  assign atWdt   = (cnt == CW'(WDT_CYCLES - 1));
  assign atPulse = (cnt == CW'(PULSE_CYCLES - 1));

  // R5: every window ends before the counter can run past its largest limit
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!porN)
    cnt <= CW'(CNT_MAX));

endmodule

// File: rtl/sup_control.sv
module sup_control
  import sup_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        lvSync,
  input  logic        atPwrup,
  input  logic        atWdt,
  input  logic        atPulse,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        nvBusy,
  output ctlStrobes_t strobes,
  output logic        hostRstN,
  output logic        commAbort,
  output logic        cmdBlock
);

  supState_t state, stateNext;
  logic      drainWr;
  logic      kick;

  assign kick = startDet | stopDet;

  always_comb begin
    stateNext      = state;
    strobes.cntClr = 1'b0;
    strobes.cntInc = 1'b0;
    unique case (state)
      ST_LV: begin
        strobes.cntClr = 1'b1;
        if (!lvSync) stateNext = ST_PWRUP;
      end
      ST_PWRUP: begin
        if (lvSync) begin
          stateNext      = ST_LV;
          strobes.cntClr = 1'b1;
        end else if (atPwrup) begin
          stateNext      = ST_RUN;
          strobes.cntClr = 1'b1;
        end else begin
          strobes.cntInc = 1'b1;
        end
      end
      ST_RUN: begin
        if (lvSync) begin
          stateNext      = ST_LV;
          strobes.cntClr = 1'b1;
        end else if (kick) begin
          strobes.cntClr = 1'b1;
        end else if (atWdt) begin
          stateNext      = ST_WDRST;
          strobes.cntClr = 1'b1;
        end else begin
          strobes.cntInc = 1'b1;
        end
      end
      ST_WDRST: begin
        if (lvSync) begin
          stateNext      = ST_LV;
          strobes.cntClr = 1'b1;
        end else if (atPulse) begin
          stateNext      = ST_RUN;
          strobes.cntClr = 1'b1;
        end else begin
          strobes.cntInc = 1'b1;
        end
      end
      default: begin
        stateNext      = ST_LV;
        strobes.cntClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_LV;
    else       state <= stateNext;
  end

  // Write-drain flag: a write that was busy during low supply keeps new
  // commands refused until it reports done.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) drainWr <= 1'b0;
    else       drainWr <= nvBusy & (drainWr | (state == ST_LV));
  end

  assign hostRstN  = (state == ST_RUN);
  assign commAbort = (state == ST_LV);
  assign cmdBlock  = (state != ST_RUN) | drainWr;

  // R1: a synchronized supply-low flag holds the host in reset next cycle
  p_lv_reset_r1: assert property (@(posedge clk) disable iff (!porN)
    lvSync |=> !hostRstN);

  // R2: aborting traffic always comes with refused commands and a held host
  p_abort_blocks_r2: assert property (@(posedge clk) disable iff (!porN)
    commAbort |-> (cmdBlock && !hostRstN));

  // R3: a write busy during low supply keeps commands refused
  p_write_drain_r3: assert property (@(posedge clk) disable iff (!porN)
    (commAbort && nvBusy) |=> cmdBlock);

  // R4: the host is only released out of a timed hold
  p_release_path_r4: assert property (@(posedge clk) disable iff (!porN)
    $rose(hostRstN) |-> ($past(state) == ST_PWRUP || $past(state) == ST_WDRST));

  // R6: an expired interval starts a pulse on the next cycle
  p_pulse_enter_r6: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_RUN && atWdt && !kick && !lvSync) |=> (state == ST_WDRST && !hostRstN));

  // R7: bus activity cannot end a pulse early
  p_kick_ignored_r7: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_WDRST && !lvSync && !atPulse) |=> (state == ST_WDRST));

endmodule

// File: rtl/supervisor_wdt.sv
module supervisor_wdt
  import sup_pkg::*;
#(
  parameter int PWRUP_CYCLES = 20,
  parameter int WDT_CYCLES   = 30,
  parameter int PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic porN,
  input  logic lowVolt,
  input  logic startDet,
  input  logic stopDet,
  input  logic nvBusy,
  output logic hostRstN,
  output logic commAbort,
  output logic cmdBlock
);

  ctlStrobes_t strobes;
  logic        lvSync;
  logic        atPwrup;
  logic        atWdt;
  logic        atPulse;

  sup_datapath #(
    .PWRUP_CYCLES(PWRUP_CYCLES),
    .WDT_CYCLES  (WDT_CYCLES),
    .PULSE_CYCLES(PULSE_CYCLES),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk      (clk),
    .porN     (porN),
    .lowVoltIn(lowVolt),
    .strobes  (strobes),
    .lvSync   (lvSync),
    .atPwrup  (atPwrup),
    .atWdt    (atWdt),
    .atPulse  (atPulse)
  );

  sup_control u_ctl (
    .clk      (clk),
    .porN     (porN),
    .lvSync   (lvSync),
    .atPwrup  (atPwrup),
    .atWdt    (atWdt),
    .atPulse  (atPulse),
    .startDet (startDet),
    .stopDet  (stopDet),
    .nvBusy   (nvBusy),
    .strobes  (strobes),
    .hostRstN (hostRstN),
    .commAbort(commAbort),
    .cmdBlock (cmdBlock)
  );

endmodule

// File: tb/sim_supervisor_wdt.sv
`timescale 1ns/1ps
module sim_supervisor_wdt;

  localparam int PU = 20;
  localparam int WD = 30;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic porN, lowVolt, startDet, stopDet, nvBusy;
  logic hostRstN, commAbort, cmdBlock;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #2.5 clk = ~clk;

  supervisor_wdt #(.PWRUP_CYCLES(PU), .WDT_CYCLES(WD), .PULSE_CYCLES(PW)) u0 (
    .clk(clk), .porN(porN), .lowVolt(lowVolt), .startDet(startDet),
    .stopDet(stopDet), .nvBusy(nvBusy), .hostRstN(hostRstN),
    .commAbort(commAbort), .cmdBlock(cmdBlock)
  );

  // {useStop, gap, expected hostRstN before the next kick}
  localparam logic [9:0] TBL [0:6] = '{
    {1'b0, 8'd5,  1'b1},
    {1'b1, 8'd30, 1'b1},
    {1'b0, 8'd29, 1'b1},
    {1'b1, 8'd1,  1'b1},
    {1'b0, 8'd31, 1'b0},
    {1'b1, 8'd30, 1'b1},
    {1'b0, 8'd12, 1'b1}
  };

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic kickOnce(input logic useStop);
    if (useStop) stopDet = 1'b1; else startDet = 1'b1;
    step(1);
    startDet = 1'b0;
    stopDet  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    porN = 1'b0; lowVolt = 1'b0; startDet = 1'b0; stopDet = 1'b0; nvBusy = 1'b0;
    step(3);
    chk(hostRstN, 1'b0, "R2 reset hostRstN");
    chk(commAbort, 1'b1, "R2 reset commAbort");
    chk(cmdBlock, 1'b1, "R2 reset cmdBlock");
    porN = 1'b1;
    step(2 + PU);
    chk(hostRstN, 1'b0, "R4 still held before delay end");
    chk(commAbort, 1'b0, "R2 abort off during power-up hold");
    chk(cmdBlock, 1'b1, "R4 cmdBlock during hold");
    step(1);
    chk(hostRstN, 1'b1, "R4 release after delay");
    chk(cmdBlock, 1'b0, "R4 cmdBlock released");
    kickOnce(1'b0);

    // R5: kick intervals from the table
    for (int v = 0; v < 7; v++) begin
      step(int'(TBL[v][8:1]) - 1);
      chk(hostRstN, TBL[v][0], $sformatf("R5 gap %0d", TBL[v][8:1]));
      if (!TBL[v][0]) begin
        chk(commAbort, 1'b0, "R6 no abort in pulse");
        step(PW);
        chk(hostRstN, 1'b1, "R6 pulse ended");
      end
      kickOnce(TBL[v][9]);
    end

    // R5/R6/R7/R8: timeout, kicks during pulse, fresh interval
    step(WD - 1);
    chk(hostRstN, 1'b1, "R5 high just before timeout");
    step(1);
    chk(hostRstN, 1'b0, "R5 timeout pulse");
    chk(cmdBlock, 1'b1, "R6 cmdBlock in pulse");
    startDet = 1'b1; stopDet = 1'b1;
    step(PW - 2);
    startDet = 1'b0; stopDet = 1'b0;
    step(1);
    chk(hostRstN, 1'b0, "R7 kicks did not end pulse");
    step(1);
    chk(hostRstN, 1'b1, "R6 pulse exact width");
    step(WD - 1);
    chk(hostRstN, 1'b1, "R8 fresh interval high");
    step(1);
    chk(hostRstN, 1'b0, "R8 next pulse after full interval");

    // R9: supply low during a pulse
    step(2);
    lowVolt = 1'b1;
    step(2);
    chk(commAbort, 1'b0, "R1 sync delay in pulse");
    step(1);
    chk(commAbort, 1'b1, "R9 low-voltage takes over");
    step(PW + 5);
    chk(hostRstN, 1'b0, "R9 held past pulse end");
    chk(commAbort, 1'b1, "R9 abort held");

    // R3: write in progress during low supply
    nvBusy = 1'b1;
    step(3);
    lowVolt = 1'b0;
    step(3);
    chk(commAbort, 1'b0, "R2 abort off after supply good");
    step(PU - 1);
    chk(hostRstN, 1'b0, "R3 hold unaffected by nvBusy");
    step(1);
    chk(hostRstN, 1'b1, "R3 release on time with nvBusy");
    chk(cmdBlock, 1'b1, "R3 commands refused while write busy");
    kickOnce(1'b1);
    step(4);
    chk(cmdBlock, 1'b1, "R3 still refused");
    nvBusy = 1'b0;
    step(1);
    chk(cmdBlock, 1'b0, "R3 refused until write done");

    // R1: synchronizer latency in run state
    kickOnce(1'b0);
    step(3);
    lowVolt = 1'b1;
    step(2);
    chk(hostRstN, 1'b1, "R1 two-flop delay");
    step(1);
    chk(hostRstN, 1'b0, "R1 reset asserted");
    chk(commAbort, 1'b1, "R2 abort in low voltage");
    step(WD + 5);
    chk(hostRstN, 1'b0, "R1 held while flag high");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule